// File: doc/BRIEF.md
# Nibble-Serial Call Stack Engine

This block keeps the return context of a 4-bit controller in ordinary data RAM. It reaches that RAM through a port that carries one nibble at a time. On a call or interrupt entry it stores a four-nibble frame. The frame holds the 13-bit program counter together with the zero (Z) and carry (C) flags. On a return it reads the frame back and presents the recovered program counter with a one-cycle done strobe. A return from interrupt also hands back the saved Z and C flags, marked by a flag-load strobe.

The engine owns an 8-bit stack pointer, which comes out of reset at FFh. Each frame uses four consecutive addresses. PC bits 3..0 sit at the highest address and the packed flag nibble sits at the lowest. Storing a frame moves the pointer down by four, and recovering a frame moves it up by four. RAM reads are taken as asynchronous: `ram_rdata` reflects `ram_addr` within the same cycle.

Top module: `nib_stack_engine`

## Requirements
- R1: After reset, `sp` is FFh, `busy`, `done`, `ram_we` and `flag_load` are 0, and `pc_out`, `z_out` and `c_out` are 0.
- R2: A push taken at clock edge E writes in the four cycles that follow, with `ram_we` high, to addresses SP, SP-1, SP-2 and SP-3 in that order. The data is PC[3:0], then PC[7:4], then PC[11:8], then the flag nibble {Z, C, 0, PC[12]} (bit 3 = Z, bit 2 = C, bit 1 = 0, bit 0 = PC12).
- R3: At the edge that ends the last push write, `sp` becomes SP-4, and `done` is high for the following cycle.
- R4: A pop taken at edge E sets `sp` to SP+4 at E. It then reads addresses SP+4, SP+3, SP+2 and SP+1 over the four cycles that follow, with `ram_we` held low.
- R5: When a pop ends, `pc_out` holds the recovered PC in the cycle where `done` is high. For an ordinary return, `z_out` and `c_out` keep their previous values and `flag_load` stays low.
- R6: When a pop ends with `reti_req` having been high at acceptance, `z_out` and `c_out` take bits 3 and 2 of the flag nibble. `flag_load` is high only in that same `done` cycle.
- R7: `busy` is high during the four transfer cycles, and any push or pop request seen while `busy` is high is ignored.
- R8: If push and pop are requested together while idle, the push is taken.
- R9: Stack pointer arithmetic wraps modulo 256. A pop from FFh gives 03h and reads addresses 03h down to 00h.
- R10: `done` is a single-cycle pulse, never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Save-context request (call or interrupt entry) |
| pop_req | input | 1 | Restore-context request (return) |
| reti_req | input | 1 | Qualifies a pop as a return from interrupt |
| pc_in | input | 13 | Program counter to save |
| z_in | input | 1 | Zero flag to save |
| c_in | input | 1 | Carry flag to save |
| ram_rdata | input | 4 | RAM read nibble for `ram_addr` |
| ram_addr | output | 8 | RAM nibble address |
| ram_wdata | output | 4 | RAM write nibble |
| ram_we | output | 1 | RAM write enable |
| busy | output | 1 | Frame transfer in progress |
| sp | output | 8 | Current stack pointer |
| pc_out | output | 13 | Recovered program counter |
| z_out | output | 1 | Recovered zero flag |
| c_out | output | 1 | Recovered carry flag |
| flag_load | output | 1 | Flags recovered on this `done` |
| done | output | 1 | Transfer finished strobe |

## Verification
The assertions assume that requests are sampled only on clock edges and that reset is applied from time zero. They also assume that nothing outside the engine changes the RAM between writing a frame and reading it back. The bench drives every input on the falling edge, so each request is stable at the rising edge that samples it. The bench also models the RAM as a private array that only `ram_we` can modify. Requests raised during a transfer are deliberate, to show they are dropped.

// File: rtl/nib_stack_engine.sv
module nib_stack_engine #(
  parameter logic [7:0] SP_INIT = 8'hFF,
  parameter int         PC_W    = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_req,
  input  logic            pop_req,
  input  logic            reti_req,
  input  logic [PC_W-1:0] pc_in,
  input  logic            z_in,
  input  logic            c_in,
  input  logic [3:0]      ram_rdata,
  output logic [7:0]      ram_addr,
  output logic [3:0]      ram_wdata,
  output logic            ram_we,
  output logic            busy,
  output logic [7:0]      sp,
  output logic [PC_W-1:0] pc_out,
  output logic            z_out,
  output logic            c_out,
  output logic            flag_load,
  output logic            done
);
  localparam logic [7:0] FRAME = 8'd4;

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_POP} st_t;
  st_t st;
  logic [1:0]      cnt;
  logic [PC_W-1:0] pc_l;
  logic            z_l, c_l, reti_l;
  logic [3:0]      nib0, nib1, nib2;

  assign busy     = (st != S_IDLE);
  assign ram_we   = (st == S_PUSH);
  assign ram_addr = sp - {6'd0, cnt};

  always_comb begin
    case (cnt)
      2'd0:    ram_wdata = pc_l[3:0];
      2'd1:    ram_wdata = pc_l[7:4];
      2'd2:    ram_wdata = pc_l[11:8];
      default: ram_wdata = {z_l, c_l, 1'b0, pc_l[12]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= 2'd0;
      sp        <= SP_INIT;
      pc_l      <= '0;
      z_l       <= 1'b0;
      c_l       <= 1'b0;
      reti_l    <= 1'b0;
      nib0      <= 4'd0;
      nib1      <= 4'd0;
      nib2      <= 4'd0;
      pc_out    <= '0;
      z_out     <= 1'b0;
      c_out     <= 1'b0;
      flag_load <= 1'b0;
      done      <= 1'b0;
    end else begin
      done      <= 1'b0;
      flag_load <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= 2'd0;
          if (push_req) begin
            st   <= S_PUSH;
            pc_l <= pc_in;
            z_l  <= z_in;
            c_l  <= c_in;
          end else if (pop_req) begin
            st     <= S_POP;
            sp     <= sp + FRAME;
            reti_l <= reti_req;
          end
        end
        S_PUSH: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) begin
            st   <= S_IDLE;
            sp   <= sp - FRAME;
            done <= 1'b1;
          end
        end
        S_POP: begin
          cnt <= cnt + 2'd1;
          case (cnt)
            2'd0: nib0 <= ram_rdata;
            2'd1: nib1 <= ram_rdata;
            2'd2: nib2 <= ram_rdata;
            default: begin
              st     <= S_IDLE;
              done   <= 1'b1;
              pc_out <= {ram_rdata[0], nib2, nib1, nib0};
              if (reti_l) begin
                z_out     <= ram_rdata[3];
                c_out     <= ram_rdata[2];
                flag_load <= 1'b1;
              end
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nib_stack_engine_chk.sv
module nib_stack_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ram_we,
  input logic       busy,
  input logic [7:0] sp,
  input logic       flag_load,
  input logic       done
);
  p_we_in_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);

  p_push_drop4_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(ram_we)) |-> (sp == $past(sp) - 8'd4));

  p_pop_rise4_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !ram_we) |-> (sp == $past(sp) + 8'd4));

  p_flag_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load |-> done);

  p_sp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sp));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind nib_stack_engine nib_stack_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .busy(busy),
  .sp(sp), .flag_load(flag_load), .done(done)
);

// File: tb/nib_stack_engine_tb_top.sv
module nib_stack_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push_req = 0, pop_req = 0, reti_req = 0, z_in = 0, c_in = 0;
  logic [12:0] pc_in = '0;
  logic [3:0] ram_rdata, ram_wdata;
  logic [7:0] ram_addr, sp;
  logic ram_we, busy, z_out, c_out, flag_load, done;
  logic [12:0] pc_out;
  logic [3:0] mem [256];
  int n_tot = 0, n_ok = 0;

  always #2 clk = ~clk;

  nib_stack_engine dut_i (.*);

  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
  assign ram_rdata = mem[ram_addr];

  typedef struct packed {
    logic push; logic reti; logic [12:0] pc; logic z; logic c;
    logic [12:0] e_pc; logic e_z; logic e_c; logic [7:0] e_sp;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b1, 1'b0, 13'h1ABC, 1'b1, 1'b0, 13'h0000, 1'b0, 1'b0, 8'hFB},
    '{1'b1, 1'b0, 13'h0123, 1'b0, 1'b1, 13'h0000, 1'b0, 1'b0, 8'hF7},
    '{1'b1, 1'b0, 13'h1FFF, 1'b1, 1'b1, 13'h0000, 1'b0, 1'b0, 8'hF3},
    '{1'b0, 1'b1, 13'h0000, 1'b0, 1'b0, 13'h1FFF, 1'b1, 1'b1, 8'hF7},
    '{1'b0, 1'b0, 13'h0000, 1'b0, 1'b0, 13'h0123, 1'b1, 1'b1, 8'hFB},
    '{1'b1, 1'b0, 13'h0A5A, 1'b0, 1'b0, 13'h0000, 1'b1, 1'b1, 8'hF7},
    '{1'b0, 1'b1, 13'h0000, 1'b0, 1'b0, 13'h0A5A, 1'b0, 1'b0, 8'hFB},
    '{1'b0, 1'b1, 13'h0000, 1'b0, 1'b0, 13'h1ABC, 1'b1, 1'b0, 8'hFF}
  };

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tot++;
    if (ok) n_ok++;
    else $display("FAIL %s: actual %h expected %h", req, act, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_ok, n_tot);
    $finish;
  endtask

  logic [7:0] a_log [4];
  logic [3:0] w_log [4];
  logic       we_log [4];
  logic       busy_log [4];

  // request at negedge, sample the four transfer cycles, end in the done cycle
  task automatic op(input logic pu, input logic po, input logic rt, input logic [12:0] pc,
                    input logic z, input logic c);
    push_req = pu; pop_req = po; reti_req = rt; pc_in = pc; z_in = z; c_in = c;
    @(negedge clk);
    push_req = 0; pop_req = 0; reti_req = 0;
    for (int k = 0; k < 4; k++) begin
      a_log[k] = ram_addr; w_log[k] = ram_wdata; we_log[k] = ram_we; busy_log[k] = busy;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tot++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 4'h0;
    repeat (3) @(negedge clk);
    chk(sp == 8'hFF && !busy && !done && !ram_we && !flag_load, "R1", {8'h0, sp}, 16'h00FF);
    chk(pc_out == 13'h0 && !z_out && !c_out, "R1", {3'b0, pc_out}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      automatic logic [7:0] sp0 = sp;
      op(TBL[v].push, !TBL[v].push, TBL[v].reti, TBL[v].pc, TBL[v].z, TBL[v].c);
      chk(done == 1'b1, "R3/R5 done", {15'b0, done}, 16'h1);
      chk(sp == TBL[v].e_sp, "R3/R4 sp", {8'h0, sp}, {8'h0, TBL[v].e_sp});
      for (int k = 0; k < 4; k++)
        chk(busy_log[k], "R7 busy", {15'b0, busy_log[k]}, 16'h1);
      if (TBL[v].push) begin
        for (int k = 0; k < 4; k++) begin
          automatic logic [3:0] ew = (k == 0) ? TBL[v].pc[3:0] : (k == 1) ? TBL[v].pc[7:4] :
                                     (k == 2) ? TBL[v].pc[11:8] : {TBL[v].z, TBL[v].c, 1'b0, TBL[v].pc[12]};
          chk(we_log[k] && a_log[k] == sp0 - 8'(k) && w_log[k] == ew, "R2 frame",
              {3'b0, we_log[k], a_log[k], w_log[k]}, {4'h1, sp0 - 8'(k), ew});
        end
      end else begin
        for (int k = 0; k < 4; k++)
          chk(!we_log[k] && a_log[k] == TBL[v].e_sp - 8'(k), "R4 read order",
              {7'b0, we_log[k], a_log[k]}, {8'h0, TBL[v].e_sp - 8'(k)});
        chk(pc_out == TBL[v].e_pc, "R5 pc", {3'b0, pc_out}, {3'b0, TBL[v].e_pc});
        chk(z_out == TBL[v].e_z && c_out == TBL[v].e_c, TBL[v].reti ? "R6 flags" : "R5 flags kept",
            {14'b0, z_out, c_out}, {14'b0, TBL[v].e_z, TBL[v].e_c});
        chk(flag_load == TBL[v].reti, "R6 flag_load", {15'b0, flag_load}, {15'b0, TBL[v].reti});
      end
      @(negedge clk);
      chk(!done && !flag_load, "R10 pulse", {15'b0, done}, 16'h0);
    end

    // R9: wrap
    op(1'b0, 1'b1, 1'b0, 13'h0, 1'b0, 1'b0);
    chk(sp == 8'h03 && a_log[0] == 8'h03 && a_log[3] == 8'h00, "R9 wrap",
        {sp, a_log[3]}, 16'h0300);
    op(1'b1, 1'b0, 1'b0, 13'h0777, 1'b0, 1'b0);
    chk(sp == 8'hFF, "R9 wrap back", {8'h0, sp}, 16'h00FF);
    chk(mem[8'h03] == 4'h7 && mem[8'h00] == 4'h0, "R9 wrap write", {8'h0, mem[8'h03], mem[8'h00]}, 16'h0070);

    // R7: request during busy ignored
    push_req = 1; pc_in = 13'h0042;
    @(negedge clk);
    push_req = 0;
    @(negedge clk);
    pop_req = 1;
    @(negedge clk);
    pop_req = 0;
    repeat (3) @(negedge clk);
    chk(sp == 8'hFB && !busy, "R7 ignore", {7'b0, busy, sp}, 16'h00FB);
    op(1'b0, 1'b1, 1'b0, 13'h0, 1'b0, 1'b0);
    chk(sp == 8'hFF && pc_out == 13'h0042, "R7 frame intact", {3'b0, pc_out}, 16'h0042);

    // R8: push wins over simultaneous pop
    op(1'b1, 1'b1, 1'b1, 13'h1234, 1'b1, 1'b1);
    chk(we_log[0] && sp == 8'hFB && !flag_load, "R8 push priority", {7'b0, we_log[0], sp}, 16'h01FB);
    op(1'b0, 1'b1, 1'b1, 13'h0, 1'b0, 1'b0);
    chk(pc_out == 13'h1234 && z_out && c_out && flag_load, "R6 reti", {3'b0, pc_out}, 16'h1234);

    @(negedge clk);
    finish_run();
  end
endmodule